// File: doc/BRIEF.md
# Nine-Bit Palette Write Port

This block holds a set of 256-entry colour palettes and the register-mapped write logic that fills them. Each entry stores a 9-bit RGB333 colour (three bits each of red, green and blue) and one priority flag. A host writes through a single 8-bit data bus. A two-bit register select steers each strobe to one of four targets: the entry index, a control register, a one-byte colour port, or a two-byte colour port that carries the full nine bits plus priority.

The control register chooses which palette receives the writes. The index advances by itself after each completed colour write, so a host can stream a whole palette after a single index write. A separate read port, addressed by palette and entry, gives the video path the stored colour one clock later.

Top module: `pal9_write_port`

## Requirements
- R1: After reset, `rd_color` and `rd_prio` are 0. The entry index is 0, the target palette is 0 and the two-byte sequencer waits for a first byte.
- R2: A write with `wr_sel`=0 (index register) loads `wr_data` into the entry index. The next colour write updates that entry.
- R3: A write with `wr_sel`=2 (one-byte colour) stores `wr_data` as RRRGGGBB: red from bits 7:5, green from bits 4:2 and the upper blue bits from bits 1:0. The lowest blue bit is the OR of `wr_data[1:0]` and the priority flag is 0.
- R4: A write with `wr_sel`=3 while the sequencer waits for a first byte only holds `wr_data` as RRRGGGBB. No palette entry changes and the index stays put.
- R5: The next `wr_sel`=3 write completes the pair. Its bit 0 becomes the lowest blue bit and its bit 7 the priority flag, and its bits 6:1 are ignored. The entry then holds the held first byte with these two bits.
- R6: The index increments after every one-byte colour write and after every second byte of a pair, and it wraps from 255 to 0.
- R7: An index register write returns the two-byte sequencer to the first-byte state.
- R8: A write with `wr_sel`=1 (control) sets the target palette from `wr_data[6:4]`; its other bits have no effect. When the code is not below NUM_PAL (4 by default), colour writes change no palette, but the index still advances.
- R9: The read port returns the entry addressed by `rd_pal` and `rd_idx` on `rd_color` as {R[2:0],G[2:0],B[2:0]} with the flag on `rd_prio`, one clock after the address is presented. A `rd_pal` not below NUM_PAL reads as 0.
- R10: A one-byte colour write also returns the two-byte sequencer to the first-byte state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 index, 1 control, 2 one-byte colour, 3 two-byte colour |
| wr_data | input | 8 | Write data |
| rd_pal | input | 3 | Palette to read |
| rd_idx | input | 8 | Entry to read |
| rd_color | output | 9 | Colour read, {R,G,B} three bits each |
| rd_prio | output | 1 | Priority flag read |

## Verification
The one-byte port is driven with colours whose two upper blue bits are 00, 01, 10 and 11. This separates the OR fill of the low blue bit from a plain zero or copy. Byte pairs are sent with second bytes that set only bit 0, only bit 7, or carry junk in bits 6:1, which shows that only the two defined bits are taken. Pairs are also broken by an index write or a one-byte write and then resumed. An unreset sequencer would merge the stale held byte into the wrong entry, so these streams tell the two cases apart. Control writes with junk outside bits 6:4 and with an out-of-range palette code, followed by reads of neighbouring palettes and entries, separate correct routing from stray writes and a stalled index.

// File: rtl/pal9_pkg.sv
package pal9_pkg;

   localparam int PAL_SEL_W = 3;
   localparam int BYTE_W    = 8;

   typedef enum logic [1:0] {
      REG_INDEX = 2'd0,
      REG_CTRL  = 2'd1,
      REG_VAL8  = 2'd2,
      REG_VAL9  = 2'd3
   } pal9_reg_e;

   typedef struct packed {
      logic       prio;
      logic [2:0] red;
      logic [2:0] grn;
      logic [2:0] blu;
   } pal9_entry_t;

   function automatic pal9_entry_t expand_byte(input logic [7:0] c);
      pal9_entry_t e;
      e.prio = 1'b0;
      e.red  = c[7:5];
      e.grn  = c[4:2];
      e.blu  = {c[1:0], c[1] | c[0]};
      return e;
   endfunction

   function automatic pal9_entry_t join_pair(input logic [7:0] first, input logic [7:0] second);
      pal9_entry_t e;
      e.prio = second[7];
      e.red  = first[7:5];
      e.grn  = first[4:2];
      e.blu  = {first[1:0], second[0]};
      return e;
   endfunction

endpackage

// File: rtl/pal9_seq.sv
module pal9_seq
   import pal9_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int NUM_PAL = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  pal9_reg_e            wr_sel,
   input  logic [BYTE_W-1:0]    wr_data,
   output logic                 we,
   output logic [PAL_SEL_W-1:0] w_pal,
   output logic [IDX_W-1:0]     w_idx,
   output pal9_entry_t          w_entry
);

   logic [IDX_W-1:0]     idx_q;
   logic [PAL_SEL_W-1:0] pal_q;
   logic                 second_q;
   logic [BYTE_W-1:0]    hold_q;

   logic is_idx, is_ctrl, is_v8, is_v9, commit, pal_ok;

   always_comb begin
      is_idx  = wr_en && (wr_sel == REG_INDEX);
      is_ctrl = wr_en && (wr_sel == REG_CTRL);
      is_v8   = wr_en && (wr_sel == REG_VAL8);
      is_v9   = wr_en && (wr_sel == REG_VAL9);
      commit  = is_v8 || (is_v9 && second_q);
      pal_ok  = (32'(pal_q) < NUM_PAL);
      we      = commit && pal_ok;
      w_pal   = pal_q;
      w_idx   = idx_q;
      w_entry = is_v8 ? expand_byte(wr_data) : join_pair(hold_q, wr_data);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q    <= '0;
         pal_q    <= '0;
         second_q <= 1'b0;
         hold_q   <= '0;
      end else begin
         if (is_idx)
            idx_q <= wr_data[IDX_W-1:0];
         else if (commit)
            idx_q <= idx_q + 1'b1;

         if (is_ctrl)
            pal_q <= wr_data[6:4];

         if (is_idx || is_v8)
            second_q <= 1'b0;
         else if (is_v9)
            second_q <= ~second_q;

         if (is_v9 && !second_q)
            hold_q <= wr_data;
      end
   end

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      is_idx |=> (idx_q == $past(wr_data[IDX_W-1:0]))); // R2

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (is_v8 || (is_v9 && second_q)) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1))); // R6

   AST_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_v9 && !second_q) |-> !we); // R4

   AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      is_idx |=> !second_q); // R7

   AST_V8_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      is_v8 |=> !second_q); // R10

endmodule

// File: rtl/pal9_bank.sv
module pal9_bank
   import pal9_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] w_idx,
   input  pal9_entry_t      w_entry,
   input  logic [IDX_W-1:0] r_idx,
   output pal9_entry_t      r_entry
);

   localparam int DEPTH = 1 << IDX_W;

   pal9_entry_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[w_idx] <= w_entry;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         r_entry <= '0;
      else
         r_entry <= mem[r_idx];
   end

endmodule

// File: rtl/pal9_ram.sv
module pal9_ram
   import pal9_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int NUM_PAL = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [PAL_SEL_W-1:0] w_pal,
   input  logic [IDX_W-1:0]     w_idx,
   input  pal9_entry_t          w_entry,
   input  logic [PAL_SEL_W-1:0] r_pal,
   input  logic [IDX_W-1:0]     r_idx,
   output pal9_entry_t          r_entry
);

   pal9_entry_t          bank_rd [NUM_PAL];
   logic [PAL_SEL_W-1:0] r_pal_q;

   for (genvar g = 0; g < NUM_PAL; g++) begin : g_bank
      logic bank_we;
      assign bank_we = we && (w_pal == PAL_SEL_W'(g));
      pal9_bank #(.IDX_W(IDX_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (bank_we),
         .w_idx   (w_idx),
         .w_entry (w_entry),
         .r_idx   (r_idx),
         .r_entry (bank_rd[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         r_pal_q <= '0;
      else
         r_pal_q <= r_pal;
   end

   always_comb begin
      r_entry = '0;
      for (int k = 0; k < NUM_PAL; k++)
         if (r_pal_q == PAL_SEL_W'(k))
            r_entry = bank_rd[k];
   end

   AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(r_pal_q) >= NUM_PAL) |-> (r_entry == '0)); // R9

endmodule

// File: rtl/pal9_write_port.sv
module pal9_write_port
   import pal9_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int NUM_PAL = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [7:0]           wr_data,
   input  logic [2:0]           rd_pal,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [8:0]           rd_color,
   output logic                 rd_prio
);

   if (NUM_PAL < 1 || NUM_PAL > (1 << PAL_SEL_W)) begin : g_bad_pal
      $error("NUM_PAL must lie in 1..8");
   end
   if (IDX_W < 1 || IDX_W > BYTE_W) begin : g_bad_idx
      $error("IDX_W must lie in 1..8");
   end

   logic                 we;
   logic [PAL_SEL_W-1:0] w_pal;
   logic [IDX_W-1:0]     w_idx;
   pal9_entry_t          w_entry;
   pal9_entry_t          r_entry;

   pal9_seq #(.IDX_W(IDX_W), .NUM_PAL(NUM_PAL)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (pal9_reg_e'(wr_sel)),
      .wr_data (wr_data),
      .we      (we),
      .w_pal   (w_pal),
      .w_idx   (w_idx),
      .w_entry (w_entry)
   );

   pal9_ram #(.IDX_W(IDX_W), .NUM_PAL(NUM_PAL)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .w_pal   (w_pal),
      .w_idx   (w_idx),
      .w_entry (w_entry),
      .r_pal   (rd_pal),
      .r_idx   (rd_idx),
      .r_entry (r_entry)
   );

   assign rd_color = {r_entry.red, r_entry.grn, r_entry.blu};
   assign rd_prio  = r_entry.prio;

   AST_BAD_PAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(w_pal) >= NUM_PAL) |-> !we); // R8

   AST_PAIR_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      we && wr_sel == 2'd3 |-> (w_entry.blu[0] == wr_data[0]) && (w_entry.prio == wr_data[7])); // R5

endmodule

// File: tb/pal9_write_port_tb.sv
`timescale 1ns/1ps
module pal9_write_port_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [2:0] rd_pal = 3'd0;
   logic [7:0] rd_idx = 8'd0;
   logic [8:0] rd_color;
   logic       rd_prio;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   pal9_write_port u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_pal(rd_pal), .rd_idx(rd_idx), .rd_color(rd_color), .rd_prio(rd_prio)
   );

   // model state, derived from the requirements
   logic [9:0] mdl [4][256];
   logic [7:0] m_idx = 8'd0;
   logic [2:0] m_pal = 3'd0;
   logic       m_second = 1'b0;
   logic [7:0] m_hold = 8'd0;

   // scoreboard
   logic [9:0] q_exp [$];
   string      q_tag [$];
   logic       rd_req = 1'b0;
   logic       rd_req_d = 1'b0;

   task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d; rd_req = 1'b0;
      case (s)
         2'd0: begin m_idx = d; m_second = 1'b0; end
         2'd1: m_pal = d[6:4];
         2'd2: begin
            if (m_pal < 3'd4) mdl[m_pal[1:0]][m_idx] = {1'b0, d, d[1] | d[0]};
            m_idx = m_idx + 8'd1;
            m_second = 1'b0;
         end
         default: begin
            if (!m_second) begin
               m_hold = d; m_second = 1'b1;
            end else begin
               if (m_pal < 3'd4) mdl[m_pal[1:0]][m_idx] = {d[7], m_hold, d[0]};
               m_idx = m_idx + 8'd1;
               m_second = 1'b0;
            end
         end
      endcase
   endtask

   task automatic rd(input logic [2:0] p, input logic [7:0] i, input string tag);
      @(negedge clk);
      wr_en = 1'b0; rd_pal = p; rd_idx = i; rd_req = 1'b1;
      q_exp.push_back((p < 3'd4) ? mdl[p[1:0]][i] : 10'd0);
      q_tag.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0; rd_req = 1'b0;
   endtask

   always @(posedge clk) rd_req_d <= rd_req;

   always @(negedge clk) begin
      if (rd_req_d) begin
         if (q_exp.size() == 0) begin
            checks++; failures++;
            $display("FAIL R9 got=%h exp=none", {rd_prio, rd_color});
         end else begin
            check(q_tag.pop_front(), {rd_prio, rd_color}, q_exp.pop_front());
         end
      end
   end

   initial begin
      #1000000;
      failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {rd_prio, rd_color}, 10'd0);
      // first write after reset lands in palette 0 entry 0
      wr(2'd2, 8'h5A);
      rd(3'd0, 8'd0, "R1");
      // one-byte colours, blue bits 11, 10, 00, 01
      wr(2'd0, 8'd10);
      wr(2'd2, 8'hE3);
      wr(2'd2, 8'h1E);
      wr(2'd2, 8'h00);
      wr(2'd2, 8'h25);
      rd(3'd0, 8'd10, "R3");
      rd(3'd0, 8'd11, "R3");
      rd(3'd0, 8'd12, "R3");
      rd(3'd0, 8'd13, "R6");
      // pairs in palette 1
      wr(2'd1, 8'h10);
      wr(2'd0, 8'd20);
      wr(2'd3, 8'hA5);
      wr(2'd3, 8'h81);
      wr(2'd3, 8'h4C);
      wr(2'd3, 8'h7E);
      rd(3'd1, 8'd20, "R5");
      rd(3'd1, 8'd21, "R5");
      // first byte alone changes nothing
      wr(2'd0, 8'd30);
      wr(2'd2, 8'hFF);
      wr(2'd0, 8'd30);
      wr(2'd3, 8'h00);
      rd(3'd1, 8'd30, "R4");
      wr(2'd3, 8'h80);
      rd(3'd1, 8'd30, "R4");
      // index write restarts the pair
      wr(2'd0, 8'd40);
      wr(2'd3, 8'hFF);
      wr(2'd0, 8'd40);
      wr(2'd3, 8'h00);
      wr(2'd3, 8'h00);
      wr(2'd2, 8'h03);
      rd(3'd1, 8'd40, "R7");
      rd(3'd1, 8'd41, "R7");
      // one-byte write restarts the pair
      wr(2'd0, 8'd50);
      wr(2'd3, 8'hE0);
      wr(2'd2, 8'h1C);
      wr(2'd3, 8'h00);
      wr(2'd3, 8'h01);
      rd(3'd1, 8'd50, "R10");
      rd(3'd1, 8'd51, "R10");
      // wrap 255 -> 0
      wr(2'd0, 8'd255);
      wr(2'd2, 8'h20);
      wr(2'd2, 8'h40);
      rd(3'd1, 8'd255, "R6");
      rd(3'd1, 8'd0, "R6");
      wr(2'd0, 8'd255);
      wr(2'd3, 8'h6D);
      wr(2'd3, 8'h81);
      wr(2'd2, 8'h9B);
      rd(3'd1, 8'd255, "R6");
      rd(3'd1, 8'd0, "R6");
      // palette select and out-of-range code
      wr(2'd0, 8'd5);
      wr(2'd2, 8'h88);
      wr(2'd1, 8'h2F);
      wr(2'd0, 8'd5);
      wr(2'd2, 8'h44);
      wr(2'd1, 8'hA0);
      wr(2'd0, 8'd6);
      wr(2'd2, 8'h11);
      rd(3'd1, 8'd5, "R8");
      rd(3'd2, 8'd5, "R8");
      rd(3'd2, 8'd6, "R8");
      wr(2'd1, 8'h70);
      wr(2'd0, 8'd5);
      wr(2'd2, 8'hFF);
      wr(2'd1, 8'h20);
      wr(2'd2, 8'h04);
      rd(3'd2, 8'd5, "R8");
      rd(3'd1, 8'd5, "R8");
      rd(3'd2, 8'd6, "R8");
      // read port out of range and plain R2 index check
      rd(3'd6, 8'd5, "R9");
      wr(2'd0, 8'd77);
      wr(2'd2, 8'hC2);
      rd(3'd2, 8'd77, "R2");
      idle(); idle(); idle();
      if (q_exp.size() != 0) begin
         checks++; failures++;
         $display("FAIL R9 got=%0d exp=0 pending", q_exp.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule